// File: doc/BRIEF.md
# Planar YUV capture address generator

The block accepts a 4:2:2 pixel stream in which every pixel carries one luma byte and one chroma byte. Chroma alternates within a line: the first pixel of a line carries U, the second carries V, and so on. The block separates the bytes into three planes (Y, U and V). It packs each plane into 32-bit words and emits memory write requests. Each request carries a byte address, byte enables and a plane tag. Software programs a 64-byte-aligned start address and a 16-bit line stride for each plane. It also programs a line count for the frame and an optional line threshold. A capture then starts when the capture-done acknowledge bit is written while the block is idle.

Each plane keeps its own running word pointer and its own line-start pointer. Both are loaded from the base register only when a capture starts. At every accepted end-of-line pixel, the stride that is programmed at that moment is added to the line-start pointer. Any partly filled word is flushed at that point with only its used byte lanes enabled. After the programmed number of lines, the block stops taking pixels and drains its pending words. It then raises a sticky capture-done flag. A second sticky flag reports that a programmed luma line count has been reached. Each flag has an interrupt enable and a write-one acknowledge. A field flag copies the incoming field identifier at each vertical-blanking pulse.

Both data paths are valid/ready streams. A pixel is taken in a cycle where vid_valid and vid_ready are both high. vid_ready is high only while capturing and while no packed word is waiting, so a completed word stalls the pixel stream until it is written. A write is taken in a cycle where wr_valid and wr_ready are both high. While wr_ready is low, the write stays valid and does not change. Words that complete on the same pixel leave in the order Y, U, V.

Top module: `yuv_plane_writer`

## Requirements
- R1: Registers are selected by the word index reg_addr and are written when reg_we is high: 0 is control, 1/2/3 are the Y/U/V base, 4/5/6 are the Y/U/V stride (bits 15:0, unsigned), 7 is the line count, and 8 is the threshold. Bits 5:0 of a written base are stored as zero, so the first word of each plane in a capture is written at the base with its six low bits cleared.
- R2: Control bit 0 selects the byte order. When it is 0, the first sample of a word goes to wr_data[31:24] and later samples go to lower lanes. When it is 1, the first sample goes to wr_data[7:0] and later samples go to higher lanes. wr_be[k] marks wr_data[8k+7:8k] as valid.
- R3: Every accepted pixel gives one Y byte (vid_y). vid_c goes to U on even pixel positions within a line (counted from 0) and to V on odd positions. wr_plane is 0 for Y, 1 for U and 2 for V.
- R4: Within a line, successive words of a plane have addresses that step by 4. At an accepted pixel with vid_eol high, each plane's next line starts at its previous line start plus the stride value held in that cycle.
- R5: At the end of a line, a partly filled word is written with wr_be set only for its filled lanes, and its unused lanes are zero. A full word is written with wr_be = 4'hF.
- R6: A base write made during a capture does not change any address in that capture. It takes effect at the next capture start.
- R7: vid_ready is high exactly when the block is capturing and no packed word is pending. While wr_valid is high and wr_ready is low, wr_valid, wr_plane, wr_addr, wr_data and wr_be hold their values. Words completed by the same pixel are emitted in the order Y, U, V.
- R8: Writing control with bit 3 set while idle starts a capture. After the end-of-line pixel of the last programmed line is accepted, vid_ready stays low. capture_done rises in the cycle after the last pending word is written, and stays set until control is written with bit 3 set.
- R9: thresh_hit is set at the accepted end-of-line pixel that brings the luma line count of the capture to the nonzero threshold value. It is cleared by writing control with bit 4 set.
- R10: If a flag's set event and its acknowledge fall in the same cycle, the flag stays set. irq is the OR of capture_done AND control bit 1 with thresh_hit AND control bit 2.
- R11: field2 takes the value of vid_field in each cycle where vid_vblank is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| vid_valid | input | 1 | Pixel valid |
| vid_ready | output | 1 | Pixel accepted when high together with vid_valid |
| vid_y | input | 8 | Luma byte of the pixel |
| vid_c | input | 8 | Chroma byte of the pixel (U on even positions, V on odd positions) |
| vid_eol | input | 1 | Pixel is the last of its line |
| vid_field | input | 1 | Field identifier |
| vid_vblank | input | 1 | Start-of-vertical-blanking pulse |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_plane | output | 2 | Plane tag: 0 Y, 1 U, 2 V |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Packed samples |
| wr_be | output | 4 | Byte enables |
| capture_done | output | 1 | Sticky capture-complete flag |
| thresh_hit | output | 1 | Sticky line-threshold flag |
| field2 | output | 1 | Latched field identifier |
| irq | output | 1 | Interrupt request |

## Verification
The first frame uses ten-pixel lines, so each line ends with a two-byte partial luma word and a one-byte partial chroma word. That frame is captured big-endian with gaps in the pixel stream and stalls on the write side, which separates a correct lane order and hold behaviour from a wrong one. During that frame the luma base is rewritten and a chroma stride is changed between lines, which distinguishes a pointer that is loaded once per capture from one that is sampled at every line. The second frame is captured little-endian with odd line widths of seven and five pixels. In that frame a threshold acknowledge is issued in the same cycle as the line that sets the flag, which shows whether the set or the clear takes precedence. Two vertical-blanking pulses with different field values check the field flag.

// File: rtl/yuvw_pkg.sv
package yuvw_pkg;
  localparam int NPLANE     = 3;
  localparam int ALIGN_BITS = 6;

  localparam logic [3:0] RA_CTRL   = 4'd0;
  localparam logic [3:0] RA_BASE0  = 4'd1;
  localparam logic [3:0] RA_DELTA0 = 4'd4;
  localparam logic [3:0] RA_HEIGHT = 4'd7;
  localparam logic [3:0] RA_THRESH = 4'd8;

  localparam int CB_LITTLE   = 0;
  localparam int CB_IE_DONE  = 1;
  localparam int CB_IE_THR   = 2;
  localparam int CB_ACK_DONE = 3;
  localparam int CB_ACK_THR  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_FLUSH = 2'd2
  } cap_state_t;
endpackage

// File: rtl/yuvw_regs.sv
module yuvw_regs
  import yuvw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int LW = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [3:0]                   addr,
  input  logic [31:0]                  wdata,
  output logic [NPLANE-1:0][AW-1:0]    base,
  output logic [NPLANE-1:0][DW-1:0]    delta,
  output logic [LW-1:0]                height,
  output logic [LW-1:0]                thresh,
  output logic                         little,
  output logic                         ie_done,
  output logic                         ie_thr,
  output logic                         ack_done,
  output logic                         ack_thr
);
  logic ctrl_wr;
  assign ctrl_wr  = we && (addr == RA_CTRL);
  assign ack_done = ctrl_wr && wdata[CB_ACK_DONE];
  assign ack_thr  = ctrl_wr && wdata[CB_ACK_THR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      little  <= 1'b0;
      ie_done <= 1'b0;
      ie_thr  <= 1'b0;
      height  <= '0;
      thresh  <= '0;
    end else if (we) begin
      if (addr == RA_CTRL) begin
        little  <= wdata[CB_LITTLE];
        ie_done <= wdata[CB_IE_DONE];
        ie_thr  <= wdata[CB_IE_THR];
      end
      if (addr == RA_HEIGHT) height <= wdata[LW-1:0];
      if (addr == RA_THRESH) thresh <= wdata[LW-1:0];
    end
  end

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base[p]  <= '0;
        delta[p] <= '0;
      end else if (we) begin
        if (addr == RA_BASE0 + 4'(p))
          base[p] <= {wdata[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        if (addr == RA_DELTA0 + 4'(p))
          delta[p] <= wdata[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/yuvw_lane.sv
module yuvw_lane #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] delta,
  input  logic          little,
  input  logic          smp,
  input  logic [7:0]    smp_byte,
  input  logic          line_end,
  input  logic          emit,
  output logic          pend,
  output logic [AW-1:0] p_addr,
  output logic [31:0]   p_data,
  output logic [3:0]    p_be
);
  logic [1:0]    cnt;
  logic [31:0]   acc;
  logic [3:0]    be;
  logic [AW-1:0] wptr;
  logic [AW-1:0] lbase;

  logic [1:0]    lane;
  logic [31:0]   acc_n;
  logic [3:0]    be_n;
  logic          fill;
  logic          flush;
  logic [AW-1:0] next_line;

  always_comb begin
    lane      = little ? cnt : ~cnt;
    acc_n     = acc;
    be_n      = be;
    if (smp) begin
      acc_n = acc | ({24'd0, smp_byte} << {lane, 3'b000});
      be_n  = be | (4'b0001 << lane);
    end
    fill      = smp && (cnt == 2'd3);
    flush     = fill || (line_end && (be_n != 4'd0));
    next_line = lbase + {{(AW-DW){1'b0}}, delta};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      be     <= '0;
      wptr   <= '0;
      lbase  <= '0;
      pend   <= 1'b0;
      p_addr <= '0;
      p_data <= '0;
      p_be   <= '0;
    end else if (start) begin
      cnt   <= '0;
      acc   <= '0;
      be    <= '0;
      wptr  <= base;
      lbase <= base;
      pend  <= 1'b0;
    end else begin
      if (emit) pend <= 1'b0;
      if (flush) begin
        pend   <= 1'b1;
        p_addr <= wptr;
        p_data <= acc_n;
        p_be   <= be_n;
        acc    <= '0;
        be     <= '0;
        cnt    <= '0;
      end else if (smp) begin
        acc <= acc_n;
        be  <= be_n;
        cnt <= cnt + 2'd1;
      end
      if (line_end) begin
        wptr  <= next_line;
        lbase <= next_line;
      end else if (fill) begin
        wptr <= wptr + AW'(4);
      end
    end
  end
endmodule

// File: rtl/yuvw_wr_arb.sv
module yuvw_wr_arb
  import yuvw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [NPLANE-1:0]          pend,
  input  logic [NPLANE-1:0][AW-1:0]  addr,
  input  logic [NPLANE-1:0][31:0]    data,
  input  logic [NPLANE-1:0][3:0]     be,
  input  logic                       wr_ready,
  output logic                       wr_valid,
  output logic [1:0]                 wr_plane,
  output logic [AW-1:0]              wr_addr,
  output logic [31:0]                wr_data,
  output logic [3:0]                 wr_be,
  output logic [NPLANE-1:0]          emit
);
  logic [1:0] sel;

  always_comb begin
    sel = 2'd0;
    for (int p = NPLANE - 1; p >= 0; p--) begin
      if (pend[p]) sel = 2'(p);
    end
  end

  assign wr_valid = |pend;
  assign wr_plane = sel;
  assign wr_addr  = addr[sel];
  assign wr_data  = data[sel];
  assign wr_be    = be[sel];

  for (genvar p = 0; p < NPLANE; p++) begin : g_emit
    assign emit[p] = wr_valid && wr_ready && (sel == 2'(p));
  end
endmodule

// File: rtl/yuv_plane_writer.sv
module yuv_plane_writer
  import yuvw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic          vid_valid,
  output logic          vid_ready,
  input  logic [7:0]    vid_y,
  input  logic [7:0]    vid_c,
  input  logic          vid_eol,
  input  logic          vid_field,
  input  logic          vid_vblank,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [1:0]    wr_plane,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_be,
  output logic          capture_done,
  output logic          thresh_hit,
  output logic          field2,
  output logic          irq
);
  logic [NPLANE-1:0][AW-1:0] base;
  logic [NPLANE-1:0][DW-1:0] delta;
  logic [LW-1:0]             height;
  logic [LW-1:0]             thresh;
  logic little, ie_done, ie_thr, ack_done, ack_thr;

  yuvw_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .base     (base),
    .delta    (delta),
    .height   (height),
    .thresh   (thresh),
    .little   (little),
    .ie_done  (ie_done),
    .ie_thr   (ie_thr),
    .ack_done (ack_done),
    .ack_thr  (ack_thr)
  );

  cap_state_t    st;
  logic [LW-1:0] line_cnt;
  logic [LW-1:0] nxt_line;
  logic          odd;
  logic          any_pend;
  logic          accept, eol_acc, last_line, arm, done_set, thr_set;

  logic [NPLANE-1:0]          pend;
  logic [NPLANE-1:0][AW-1:0]  p_addr;
  logic [NPLANE-1:0][31:0]    p_data;
  logic [NPLANE-1:0][3:0]     p_be;
  logic [NPLANE-1:0]          emit;
  logic [NPLANE-1:0]          smp;
  logic [NPLANE-1:0][7:0]     smp_byte;

  assign any_pend  = |pend;
  assign vid_ready = (st == ST_CAPT) && !any_pend;
  assign accept    = vid_valid && vid_ready;
  assign eol_acc   = accept && vid_eol;
  assign nxt_line  = line_cnt + 1'b1;
  assign last_line = eol_acc && (nxt_line == height);
  assign arm       = ack_done && (st == ST_IDLE);
  assign done_set  = (st == ST_FLUSH) && !any_pend;
  assign thr_set   = eol_acc && (thresh != '0) && (nxt_line == thresh);

  assign smp      = {accept && odd, accept && !odd, accept};
  assign smp_byte = {vid_c, vid_c, vid_y};

  for (genvar p = 0; p < NPLANE; p++) begin : g_lane
    yuvw_lane #(.AW(AW), .DW(DW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (arm),
      .base     (base[p]),
      .delta    (delta[p]),
      .little   (little),
      .smp      (smp[p]),
      .smp_byte (smp_byte[p]),
      .line_end (eol_acc),
      .emit     (emit[p]),
      .pend     (pend[p]),
      .p_addr   (p_addr[p]),
      .p_data   (p_data[p]),
      .p_be     (p_be[p])
    );
  end

  yuvw_wr_arb #(.AW(AW)) u_arb (
    .pend     (pend),
    .addr     (p_addr),
    .data     (p_data),
    .be       (p_be),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_plane (wr_plane),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .emit     (emit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      line_cnt     <= '0;
      odd          <= 1'b0;
      capture_done <= 1'b0;
      thresh_hit   <= 1'b0;
      field2       <= 1'b0;
    end else begin
      case (st)
        ST_IDLE:  if (arm)       st <= ST_CAPT;
        ST_CAPT:  if (last_line) st <= ST_FLUSH;
        ST_FLUSH: if (done_set)  st <= ST_IDLE;
        default:                 st <= ST_IDLE;
      endcase
      if (arm)          line_cnt <= '0;
      else if (eol_acc) line_cnt <= nxt_line;
      if (arm || eol_acc) odd <= 1'b0;
      else if (accept)    odd <= !odd;
      capture_done <= done_set || (capture_done && !ack_done);
      thresh_hit   <= thr_set  || (thresh_hit && !ack_thr);
      if (vid_vblank) field2 <= vid_field;
    end
  end

  assign irq = (capture_done && ie_done) || (thresh_hit && ie_thr);
endmodule

// File: rtl/yuvw_chk.sv
module yuvw_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic          ack_bit,
  input logic          vid_ready,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [1:0]    wr_plane,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic [3:0]    wr_be,
  input logic          capture_done,
  input logic          thresh_hit,
  input logic          irq
);
  logic ack_w;
  assign ack_w = reg_we && (reg_addr == 4'd0) && ack_bit;

  p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ready |-> !wr_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                 && $stable(wr_be) && $stable(wr_plane)));

  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be != 4'd0));

  p_done_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_done) |-> !$past(wr_valid));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_done |-> !vid_ready);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_done && !ack_w) |=> capture_done);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (capture_done || thresh_hit));
endmodule

bind yuv_plane_writer yuvw_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .ack_bit      (reg_wdata[3]),
  .vid_ready    (vid_ready),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_plane     (wr_plane),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .wr_be        (wr_be),
  .capture_done (capture_done),
  .thresh_hit   (thresh_hit),
  .irq          (irq)
);

// File: tb/tb_yuv_plane_writer.sv
`timescale 1ns/1ps
module tb_yuv_plane_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        vid_valid = 1'b0;
  logic        vid_ready;
  logic [7:0]  vid_y = '0;
  logic [7:0]  vid_c = '0;
  logic        vid_eol = 1'b0;
  logic        vid_field = 1'b0;
  logic        vid_vblank = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [1:0]  wr_plane;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        capture_done, thresh_hit, field2, irq;

  always #10 clk = ~clk;

  yuv_plane_writer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_y(vid_y), .vid_c(vid_c),
    .vid_eol(vid_eol), .vid_field(vid_field), .vid_vblank(vid_vblank),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_plane(wr_plane), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .capture_done(capture_done),
    .thresh_hit(thresh_hit), .field2(field2), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  int          mst = 0;          // 0 idle, 1 capturing, 2 draining
  int          mlines = 0;
  bit          mpar = 0;
  bit          mdone = 0, mthr = 0, mfld = 0;
  logic [31:0] mbase [3];
  logic [15:0] mdelta [3];
  int          mheight = 0, mthresh = 0;
  logic [2:0]  mctl = '0;
  logic [31:0] macc [3];
  logic [3:0]  mbe [3];
  int          mcnt [3];
  logic [31:0] mwp [3];
  logic [31:0] mlb [3];
  logic [69:0] q [$];
  bit          last_acc = 0;

  task automatic chk(input bit ok, input string tag, input logic [69:0] act, input logic [69:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic mdl_plane(input int p, input logic [7:0] b, input bit has, input bit eol);
    int lane;
    bit flush;
    flush = 0;
    if (has) begin
      lane = mctl[0] ? mcnt[p] : 3 - mcnt[p];
      macc[p][lane*8 +: 8] = b;
      mbe[p][lane] = 1'b1;
      mcnt[p]++;
      if (mcnt[p] == 4) flush = 1;
    end
    if (eol && mbe[p] != 4'd0) flush = 1;
    if (flush) begin
      q.push_back({2'(p), mwp[p], macc[p], mbe[p]});
      macc[p] = '0;
      mbe[p] = '0;
      mcnt[p] = 0;
      if (!eol) mwp[p] = mwp[p] + 32'd4;
    end
    if (eol) begin
      mlb[p] = mlb[p] + {16'd0, mdelta[p]};
      mwp[p] = mlb[p];
    end
  endtask

  task automatic step();
    int st0;
    bit acc, pop, dset, ackd, ackt, tset, exp_rdy;
    wr_ready = (cyc % 3) != 2;
    exp_rdy = (mst == 1) && (q.size() == 0);
    chk(vid_ready === exp_rdy, "R7 vid_ready", 70'(vid_ready), 70'(exp_rdy));
    chk(wr_valid === (q.size() != 0), "R7 wr_valid", 70'(wr_valid), 70'(q.size() != 0));
    if (q.size() != 0 && wr_valid) begin
      chk(wr_plane === q[0][69:68], "R3 wr_plane", 70'(wr_plane), 70'(q[0][69:68]));
      chk(wr_addr === q[0][67:36], "R4 wr_addr", 70'(wr_addr), 70'(q[0][67:36]));
      chk(wr_data === q[0][35:4], "R2 wr_data", 70'(wr_data), 70'(q[0][35:4]));
      chk(wr_be === q[0][3:0], "R5 wr_be", 70'(wr_be), 70'(q[0][3:0]));
    end
    chk(capture_done === mdone, "R8 capture_done", 70'(capture_done), 70'(mdone));
    chk(thresh_hit === mthr, "R9 thresh_hit", 70'(thresh_hit), 70'(mthr));
    chk(irq === ((mdone && mctl[1]) || (mthr && mctl[2])), "R10 irq", 70'(irq),
        70'((mdone && mctl[1]) || (mthr && mctl[2])));
    chk(field2 === mfld, "R11 field2", 70'(field2), 70'(mfld));

    // advance model over the coming edge
    st0  = mst;
    acc  = rst_n && vid_valid && exp_rdy;
    pop  = rst_n && (q.size() != 0) && wr_ready;
    dset = rst_n && (st0 == 2) && (q.size() == 0);
    ackd = rst_n && reg_we && reg_addr == 4'd0 && reg_wdata[3];
    ackt = rst_n && reg_we && reg_addr == 4'd0 && reg_wdata[4];
    tset = acc && vid_eol && (mthresh != 0) && (mlines + 1 == mthresh);
    last_acc = acc;
    if (pop) void'(q.pop_front());
    if (acc) begin
      mdl_plane(0, vid_y, 1'b1, vid_eol);
      mdl_plane(1, vid_c, !mpar, vid_eol);
      mdl_plane(2, vid_c, mpar, vid_eol);
      mpar = vid_eol ? 1'b0 : !mpar;
      if (vid_eol) begin
        mlines++;
        if (mlines == mheight) mst = 2;
      end
    end
    if (dset) mst = 0;
    if (ackd && st0 == 0) begin
      mst = 1;
      mlines = 0;
      mpar = 0;
      for (int p = 0; p < 3; p++) begin
        mwp[p] = mbase[p];
        mlb[p] = mbase[p];
        macc[p] = '0;
        mbe[p] = '0;
        mcnt[p] = 0;
      end
    end
    mdone = dset || (mdone && !ackd);
    mthr  = tset || (mthr && !ackt);
    if (rst_n && vid_vblank) mfld = vid_field;
    if (rst_n && reg_we) begin
      case (reg_addr)
        4'd0: mctl = reg_wdata[2:0];
        4'd1, 4'd2, 4'd3: mbase[reg_addr - 4'd1] = {reg_wdata[31:6], 6'd0};
        4'd4, 4'd5, 4'd6: mdelta[reg_addr - 4'd4] = reg_wdata[15:0];
        4'd7: mheight = int'(reg_wdata[11:0]);
        4'd8: mthresh = int'(reg_wdata[11:0]);
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  // send one pixel; optionally write control in the accepting cycle
  task automatic send_pix(input logic [7:0] y, input logic [7:0] c, input bit eol,
                          input bit with_wr, input logic [31:0] ctl);
    int guard;
    guard = 0;
    vid_valid = 1'b1;
    vid_y = y;
    vid_c = c;
    vid_eol = eol;
    last_acc = 0;
    while (!last_acc && guard < 200) begin
      if (with_wr && mst == 1 && q.size() == 0) begin
        reg_we = 1'b1;
        reg_addr = 4'd0;
        reg_wdata = ctl;
      end
      step();
      reg_we = 1'b0;
      guard++;
    end
    vid_valid = 1'b0;
    vid_eol = 1'b0;
  endtask

  task automatic send_line(input int n, input int tag, input bit ack_at_eol, input logic [31:0] ctl);
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 2) step();  // gap in the pixel stream
      send_pix(8'(tag * 16 + i), 8'(8'hA0 + tag * 16 + i), i == n - 1,
               ack_at_eol && (i == n - 1), ctl);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300 && !mdone; i++) step();
  endtask

  initial begin
    for (int p = 0; p < 3; p++) begin
      mbase[p] = '0; mdelta[p] = '0; macc[p] = '0; mbe[p] = '0;
      mcnt[p] = 0; mwp[p] = '0; mlb[p] = '0;
    end
    @(negedge clk);
    repeat (3) step();          // reset state: R7 R8 R9 R10 R11 outputs low
    rst_n = 1'b1;
    step();

    // R1: unaligned bases are stored aligned; strides per plane
    wreg(4'd1, 32'h1000_0047);
    wreg(4'd2, 32'h2000_0000);
    wreg(4'd3, 32'h3000_0010);
    wreg(4'd4, 32'h0000_0100);
    wreg(4'd5, 32'h0000_0080);
    wreg(4'd6, 32'h0000_0080);
    wreg(4'd7, 32'd3);
    wreg(4'd8, 32'd2);
    wreg(4'd0, 32'h6);          // big-endian (R2), both interrupt enables
    step();
    wreg(4'd0, 32'h6 | 32'h8);  // R8 arm
    send_line(10, 0, 0, 0);
    wreg(4'd1, 32'h0100_0080);  // R6 base write mid capture
    send_line(10, 1, 0, 0);
    wreg(4'd5, 32'h0000_0040);  // R4 stride change between lines
    send_line(10, 2, 0, 0);
    wait_done();                // R8 done after drain, R9 thr at line 2
    repeat (4) step();
    wreg(4'd0, 32'h6 | 32'h10); // R9 acknowledge threshold
    step();

    // second capture: little-endian, odd widths, set-wins on threshold (R10)
    wreg(4'd7, 32'd2);
    wreg(4'd8, 32'd1);
    wreg(4'd0, 32'h7 | 32'h8);  // R2 little-endian, R6 new base now used
    send_line(7, 3, 1, 32'h7 | 32'h10);
    send_line(5, 4, 0, 0);
    wait_done();
    repeat (3) step();
    wreg(4'd0, 32'h7 | 32'h8 | 32'h10); // clears both, rearms
    wreg(4'd0, 32'h1);                  // no effect on state while capturing

    // R11 field flag
    vid_field = 1'b1; vid_vblank = 1'b1; step();
    vid_vblank = 1'b0; vid_field = 1'b0; repeat (2) step();
    vid_vblank = 1'b1; step();
    vid_vblank = 1'b0; repeat (2) step();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule